// File: doc/BRIEF.md
# Quasi-bidirectional I/O port

This block is a general-purpose port of `W` pins, 8 by default, with bit 0 as the LSB. Each pin has an output latch. The pad can only pull a pin low, so the same pin works as an output or as an input.

- **Writing a pin.** Writing 0 to a pin's latch makes the pad drive that pin low. Writing 1 releases the pin. In pull-up mode a released pin is held high by a weak internal pull-up. In open-drain mode a released pin floats and needs an external pull-up.
- **Using a pin as an input.** A pin is usable as an input only after its latch holds 1.
- **CPU-side writes.** The CPU can write the whole byte, set or clear one addressed bit, or apply a read-modify-write operation. The read-modify-write operand is always the latch, never the pin.
- **CPU-side reads.** There are two read strobes. One returns the pin levels through a two-stage synchronizer. The other returns the latch contents.

A CPU core uses the port for simple parallel I/O. The pad cell takes an output enable, the value to drive and a pull-up enable, and returns the sampled pin level.

Top module: `qbio_port`

## Requirements
- R1: After reset the latch holds all ones, `pad_oe` is all zero, `pad_pu` is all ones in pull-up mode, and `rd_data` is zero.
- R2: When `wr_byte` is high, the latch takes `wr_data` at that clock edge. The outputs follow the latch combinationally: `pad_oe` equals the inverted latch and `pad_out` equals the latch, so every bit whose latch is 0 is driven low.
- R3: `bit_set` writes 1 and `bit_clr` writes 0 to the latch bit addressed by `bit_sel`. All other bits keep their value.
- R4: When `rmw_en` is high, the latch is replaced by an operation on the latch value and `rmw_arg`, chosen by `rmw_op`:
  - 0: AND
  - 1: OR
  - 2: XOR
  - 3: increment, modulo 2^W
  - 4: decrement, modulo 2^W
  - 5: complement
  - 6 and 7: leave the latch unchanged

  The operand is the latch value even when an external source holds the pin low.
- R5: When several write strobes are high in one cycle, only one takes effect. The order from highest to lowest is `wr_byte`, `rmw_en`, `bit_set`, `bit_clr`.
- R6: One clock edge after a `rd_pin` strobe, `rd_data` holds the pin level that was sampled two edges before the strobe edge.
- R7: One edge after a `rd_latch` strobe, `rd_data` holds the latch value as it was before that edge. If `rd_latch` and `rd_pin` are high together, the latch is returned.
- R8: `pad_pu` equals the latch in pull-up mode (`od_mode` = 0). In open-drain mode (`od_mode` = 1) `pad_pu` is zero.
- R9: A pin whose latch is 1 reads back the external level. A pin whose latch is 0 reads back 0 whatever an external source applies.
- R10: With no read strobe, `rd_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| od_mode | input | 1 | 1 selects open-drain, 0 selects pull-up |
| wr_byte | input | 1 | Write the whole latch |
| wr_data | input | W | Byte write value |
| bit_set | input | 1 | Set the addressed bit |
| bit_clr | input | 1 | Clear the addressed bit |
| bit_sel | input | $clog2(W) | Addressed bit |
| rmw_en | input | 1 | Apply a read-modify-write operation to the latch |
| rmw_op | input | 3 | Operation code (see R4) |
| rmw_arg | input | W | Second operand |
| rd_pin | input | 1 | Read pin strobe |
| rd_latch | input | 1 | Read latch strobe |
| rd_data | output | W | Registered read result |
| pad_in | input | W | Level seen at the pins |
| pad_oe | output | W | Per-pin output enable (drive low) |
| pad_out | output | W | Per-pin drive value |
| pad_pu | output | W | Per-pin weak pull-up enable |

## Verification
The write path is exercised with random mixes of simultaneous strobes and random operation codes. This separates the priority order and each operation's result from a wrong operand or a wrong code decode. Directed cases cover the following:
- A pin held low externally while its latch is 1, which tells a latch-based operand from a pin-based one.
- Increment and decrement at the wrap points.
- Both read strobes in the same cycle.
- Pin reads with patterns that mix latch zeros and external zeros, which show that a latch 0 forces the pin read to 0.
- Both pad modes, which show whether the pull-up follows the latch or is removed.

// File: rtl/qbio_port.sv
module qbio_port #(
  parameter int W = 8,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          od_mode,
  input  logic          wr_byte,
  input  logic [W-1:0]  wr_data,
  input  logic          bit_set,
  input  logic          bit_clr,
  input  logic [SW-1:0] bit_sel,
  input  logic          rmw_en,
  input  logic [2:0]    rmw_op,
  input  logic [W-1:0]  rmw_arg,
  input  logic          rd_pin,
  input  logic          rd_latch,
  output logic [W-1:0]  rd_data,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_pu
);
  logic [W-1:0] lat, nxt, s1, s2;

  always_comb begin
    nxt = lat;
    if (wr_byte) nxt = wr_data;
    else if (rmw_en) begin
      case (rmw_op)
        3'd0: nxt = lat & rmw_arg;
        3'd1: nxt = lat | rmw_arg;
        3'd2: nxt = lat ^ rmw_arg;
        3'd3: nxt = lat + 1'b1;
        3'd4: nxt = lat - 1'b1;
        3'd5: nxt = ~lat;
        default: nxt = lat;
      endcase
    end
    else if (bit_set) nxt[bit_sel] = 1'b1;
    else if (bit_clr) nxt[bit_sel] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lat <= '1;
      s1 <= '0;
      s2 <= '0;
      rd_data <= '0;
    end else begin
      lat <= nxt;
      s1 <= pad_in;
      s2 <= s1;
      if (rd_latch) rd_data <= lat;
      else if (rd_pin) rd_data <= s2;
    end

  assign pad_oe  = ~lat;
  assign pad_out = lat;
  assign pad_pu  = od_mode ? '0 : lat;
endmodule

module qbio_port_chk #(
  parameter int W = 8,
  localparam int SW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          od_mode,
  input logic          wr_byte,
  input logic [W-1:0]  wr_data,
  input logic          bit_set,
  input logic          bit_clr,
  input logic [SW-1:0] bit_sel,
  input logic          rmw_en,
  input logic          rd_pin,
  input logic          rd_latch,
  input logic [W-1:0]  rd_data,
  input logic [W-1:0]  pad_in,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  pad_pu
);
  logic [1:0] age;
  logic [SW-1:0] sel_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      age <= '0;
      sel_q <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      sel_q <= bit_sel;
    end

  // R2
  byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte |=> pad_oe == ~$past(wr_data));
  // R3
  bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_set && !wr_byte && !rmw_en) |=> !pad_oe[sel_q]);
  // R5
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_byte || rmw_en || bit_set || bit_clr) |=> $stable(pad_oe));
  // R6
  pin_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && rd_pin && !rd_latch) |=> rd_data == $past(pad_in, 3));
  // R7
  latch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_latch |=> rd_data == ~$past(pad_oe));
  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_pin || rd_latch) |=> $stable(rd_data));
  // R8
  od_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    od_mode |-> pad_pu == '0);
endmodule

bind qbio_port qbio_port_chk #(.W(W)) i_chk (.*);

// File: tb/test_qbio_port.sv
module test_qbio_port;
  localparam int W = 8;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n, od_mode, wr_byte, bit_set, bit_clr, rmw_en, rd_pin, rd_latch;
  logic [W-1:0] wr_data, rmw_arg, rd_data, pad_in, pad_oe, pad_out, pad_pu, ext;
  logic [2:0] bit_sel, rmw_op;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  qbio_port #(.W(W)) i_qbio_port (.*);

  int checks = 0, fails = 0;
  logic [W-1:0] mdl;
  bit done = 0;

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic clr_strobes;
    wr_byte = 0; bit_set = 0; bit_clr = 0; rmw_en = 0; rd_pin = 0; rd_latch = 0;
  endtask

  function automatic logic [W-1:0] rmw_f(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b);
    case (op)
      3'd0: return a & b;
      3'd1: return a | b;
      3'd2: return a ^ b;
      3'd3: return a + 1'b1;
      3'd4: return a - 1'b1;
      3'd5: return ~a;
      default: return a;
    endcase
  endfunction

  function automatic logic [W-1:0] model_next(logic [W-1:0] l);
    logic [W-1:0] n = l;
    if (wr_byte) n = wr_data;
    else if (rmw_en) n = rmw_f(rmw_op, l, rmw_arg);
    else if (bit_set) n[bit_sel] = 1'b1;
    else if (bit_clr) n[bit_sel] = 1'b0;
    return n;
  endfunction

  task automatic apply(string tag);
    mdl = model_next(mdl);
    step();
    clr_strobes();
    chk({tag, " pad_oe"}, pad_oe, ~mdl);
    chk({tag, " pad_out"}, pad_out, mdl);
  endtask

  task automatic read_latch(string tag);
    rd_latch = 1; step(); rd_latch = 0;
    chk(tag, rd_data, mdl);
  endtask

  task automatic read_pin(string tag);
    step(3);
    rd_pin = 1; step(); rd_pin = 0;
    chk(tag, rd_data, mdl & ext);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clr_strobes();
    rst_n = 0; od_mode = 0; wr_data = 0; bit_sel = 0; rmw_op = 0; rmw_arg = 0; ext = '1;
    mdl = '1;
    step(3);
    rst_n = 1;
    step();
    // R1
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pad_pu", pad_pu, '1);
    chk("R1 rd_data", rd_data, '0);
    read_latch("R1 latch");

    // R2 byte write
    wr_byte = 1; wr_data = 8'h55; apply("R2 55");
    // R8 pull-up follows latch, then open-drain
    chk("R8 pu mode", pad_pu, 8'h55);
    od_mode = 1; step();
    chk("R8 od mode", pad_pu, 8'h00);
    od_mode = 0;
    // R3 set and clear
    bit_set = 1; bit_sel = 3'd7; apply("R3 set7");
    bit_clr = 1; bit_sel = 3'd0; apply("R3 clr0");
    read_latch("R3 latch");

    // R4 latch operand with pin held low externally
    wr_byte = 1; wr_data = 8'hFF; apply("R4 ff");
    ext = 8'h00;
    rmw_en = 1; rmw_op = 3'd2; rmw_arg = 8'h0F; apply("R4 xor latch operand");
    read_latch("R4 xor f0");
    // R4 wrap
    wr_byte = 1; wr_data = 8'hFF; apply("R4 ff2");
    rmw_en = 1; rmw_op = 3'd3; apply("R4 inc wrap");
    chk("R4 inc 00", pad_out, 8'h00);
    rmw_en = 1; rmw_op = 3'd4; apply("R4 dec wrap");
    chk("R4 dec ff", pad_out, 8'hFF);
    rmw_en = 1; rmw_op = 3'd6; rmw_arg = 8'h00; apply("R4 op6 none");

    // R5 priority
    wr_byte = 1; wr_data = 8'h3C; rmw_en = 1; rmw_op = 3'd5; bit_set = 1; bit_sel = 3'd0;
    apply("R5 byte wins");
    rmw_en = 1; rmw_op = 3'd1; rmw_arg = 8'h01; bit_clr = 1; bit_sel = 3'd0;
    apply("R5 rmw wins");
    bit_set = 1; bit_clr = 1; bit_sel = 3'd6; apply("R5 set wins");

    // R6 and R9 pin reads
    wr_byte = 1; wr_data = 8'hF0; apply("R9 f0");
    ext = 8'hA5; read_pin("R9 mixed");
    ext = 8'hFF; read_pin("R6 pin ff");
    // R7 both strobes
    ext = 8'h0F; step(3);
    rd_pin = 1; rd_latch = 1; step(); clr_strobes();
    chk("R7 latch priority", rd_data, mdl);
    // R10 hold
    ext = 8'h00; step(4);
    chk("R10 hold", rd_data, mdl);

    // random mix
    for (int i = 0; i < 400; i++) begin
      wr_byte = ($urandom % 4) == 0;
      rmw_en  = ($urandom % 3) == 0;
      bit_set = ($urandom % 3) == 0;
      bit_clr = ($urandom % 3) == 0;
      wr_data = W'($urandom);
      rmw_arg = W'($urandom);
      rmw_op  = 3'($urandom);
      bit_sel = 3'($urandom);
      od_mode = 1'($urandom);
      ext = W'($urandom);
      apply("R5 random");
      chk("R8 random", pad_pu, od_mode ? '0 : mdl);
      if (i % 8 == 0) read_pin("R6 random pin");
      if (i % 8 == 4) read_latch("R7 random latch");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule